// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous SRAM. Its read data flows straight from the array in the cycle after the address is registered, and its write data arrives one cycle after the write address. Because of this, reads and writes can be interleaved on a shared data bus with no idle cycles between them. A command is registered on a rising edge: a load (advance/load low, chip enable active) opens a new single access or burst, and a continue (advance/load high) steps a 2-bit burst counter. The burst counter runs in interleaved order, or in linear order when the mode input is high at load time.

Write data waits in an input data register until the next accepted edge commits it to the array. Any read that hits that register returns the newer bytes. A clock-enable input freezes the whole pipeline. An asynchronous sleep input floats the outputs, keeps the array, and is followed by a short wake-up window in which commands are not accepted. The bidirectional data bus is split into separate in, out and output-enable ports.

Top module: `zbt_sram`

## Requirements
- R1: After an edge that registers a read of address A (with adv_i low, ce_ni low and rd_i high), dq_o carries the stored word at A in that same cycle, and dq_oe_o is high when oe_ni is low.
- R2: dq_oe_o is low whenever oe_ni is high, whenever the device is deselected, and whenever the current access is a write.
- R3: A write registers its address on one accepted edge and takes its data from dq_i on the next accepted edge.
- R4: Bit b of bw_ni (low = enabled) controls data bits [8b+7:8b]. Only enabled bytes are written, and with bw_ni all ones the write changes nothing.
- R5: A read of an address whose write data has been captured but not yet committed returns that data for the enabled bytes and the array data for the others.
- R6: In interleaved order the two low address bits are base XOR count, so a burst from low bits 01 visits 01, 00, 11, 10. The burst returns to its start after four steps.
- R7: When lbo_i is high at load, the low bits are base plus count modulo 4. lbo_i has no effect on a burst that is already running.
- R8: Continue cycles keep the read or write type set at load. A continue issued while deselected leaves the device deselected.
- R9: A load with ce_ni high deselects the device, and dq_oe_o is low from the next cycle.
- R10: An edge with cke_ni high changes nothing: dq_o, dq_oe_o, the burst position and any pending write data are held.
- R11: dq_oe_o drops as soon as zz_i goes high, without waiting for a clock edge. Array contents survive sleep.
- R12: Edges taken while zz_i is high, and the two edges after it falls, act as deselect commands.
- R13: While rst_ni is low and right after reset, dq_oe_o is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| adv_i | input | 1 | High: continue burst; low: load command |
| ce_ni | input | 1 | Chip enable, active low |
| rd_i | input | 1 | High: read; low: write |
| lbo_i | input | 1 | Burst order at load: high linear, low interleaved |
| bw_ni | input | NB | Byte write enables, active low |
| oe_ni | input | 1 | Output enable, active low |
| zz_i | input | 1 | Asynchronous sleep request |
| addr_i | input | AW | Word address |
| dq_i | input | NB*BW | Write data from the bus |
| dq_o | output | NB*BW | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The bench uses the default build: 64 words (AW=6), two 8-bit bytes, and a two-cycle wake-up window. At this depth the bench fills the whole array with a pipelined write burst before any read, so every read it compares is against known contents. With two bytes, both a partial byte mask and a full abort can be tried, and the forwarding merge shows a visible mix of new and old bytes. The short wake window lets the bench check the ignored edges and the first accepted edge one cycle at a time.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {BURST_INTLV = 1'b0, BURST_LINEAR = 1'b1} burst_mode_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input burst_mode_e mode);
    return (mode == BURST_LINEAR) ? base + cnt : base ^ cnt;
  endfunction
endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
  import zbt_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          ign_i,
  input  logic          adv_i,
  input  logic          ce_ni,
  input  logic          rd_i,
  input  logic          lbo_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_ni,
  output logic          act_o,
  output logic          rd_o,
  output logic [AW-1:0] eff_addr_o,
  output logic [NB-1:0] bw_o
);
  logic          act_q, rd_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  burst_mode_e   mode_q;
  logic [NB-1:0] bw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= BURST_INTLV;
      bw_q   <= '0;
    end else if (step_i) begin
      bw_q <= ~bw_ni;
      if (ign_i) begin
        act_q <= 1'b0;
      end else if (!adv_i) begin
        if (!ce_ni) begin
          act_q  <= 1'b1;
          rd_q   <= rd_i;
          base_q <= addr_i;
          cnt_q  <= '0;
          mode_q <= lbo_i ? BURST_LINEAR : BURST_INTLV;
        end else begin
          act_q <= 1'b0;
        end
      end else if (act_q) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign act_o      = act_q;
  assign rd_o       = rd_q;
  assign bw_o       = bw_q;
  assign eff_addr_o = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, mode_q)};
endmodule

// File: rtl/zbt_write_buf.sv
module zbt_write_buf #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_i,
  input  logic [DW-1:0] dq_i,
  output logic          cm_vld_o,
  output logic [AW-1:0] cm_addr_o,
  output logic [NB-1:0] cm_bw_o,
  output logic [DW-1:0] cm_data_o,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic          pv_q;
  logic [AW-1:0] pa_q;
  logic [NB-1:0] pb_q;
  logic [DW-1:0] pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      pa_q <= '0;
      pb_q <= '0;
      pd_q <= '0;
    end else if (step_i) begin
      pv_q <= req_i;
      pa_q <= addr_i;
      pb_q <= bw_i;
      pd_q <= dq_i;
    end
  end

  logic hit;
  assign hit = pv_q && (pa_q == rd_addr_i);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign rd_data_o[b*BW +: BW] = (hit && pb_q[b]) ? pd_q[b*BW +: BW]
                                                    : arr_data_i[b*BW +: BW];
  end

  assign cm_vld_o  = pv_q;
  assign cm_addr_o = pa_q;
  assign cm_bw_o   = pb_q;
  assign cm_data_o = pd_q;
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be_i[b]) mem_q[waddr_i][b*BW +: BW] <= wdata_i[b*BW +: BW];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW       = 6,
  parameter int NB       = 2,
  parameter int BW       = 8,
  parameter int WAKE_CYC = 2,
  localparam int DW  = NB * BW,
  localparam int WCW = $clog2(WAKE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          adv_i,
  input  logic          ce_ni,
  input  logic          rd_i,
  input  logic          lbo_i,
  input  logic [NB-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic          zz_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic           step, ign, wake_busy;
  logic [WCW-1:0] wake_q;
  logic           act, rd_op;
  logic [AW-1:0]  eff_addr;
  logic [NB-1:0]  bw_cur;
  logic           cm_vld;
  logic [AW-1:0]  cm_addr;
  logic [NB-1:0]  cm_bw;
  logic [DW-1:0]  cm_data, arr_data, rd_data;

  assign step = !cke_ni;

  // wake-up window counts every clock edge, stalled or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wake_q <= '0;
    else if (zz_i)              wake_q <= WCW'(WAKE_CYC);
    else if (wake_q != '0)      wake_q <= wake_q - 1'b1;
  end
  assign wake_busy = (wake_q != '0);
  assign ign       = zz_i || wake_busy;

  zbt_burst_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .ign_i     (ign),
    .adv_i     (adv_i),
    .ce_ni     (ce_ni),
    .rd_i      (rd_i),
    .lbo_i     (lbo_i),
    .addr_i    (addr_i),
    .bw_ni     (bw_ni),
    .act_o     (act),
    .rd_o      (rd_op),
    .eff_addr_o(eff_addr),
    .bw_o      (bw_cur)
  );

  zbt_write_buf #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .req_i     (act && !rd_op),
    .addr_i    (eff_addr),
    .bw_i      (bw_cur),
    .dq_i      (dq_i),
    .cm_vld_o  (cm_vld),
    .cm_addr_o (cm_addr),
    .cm_bw_o   (cm_bw),
    .cm_data_o (cm_data),
    .rd_addr_i (eff_addr),
    .arr_data_i(arr_data),
    .rd_data_o (rd_data)
  );

  zbt_mem_array #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (step && cm_vld),
    .be_i   (cm_bw),
    .waddr_i(cm_addr),
    .wdata_i(cm_data),
    .raddr_i(eff_addr),
    .rdata_o(arr_data)
  );

  assign dq_o    = rd_data;
  assign dq_oe_o = act && rd_op && !oe_ni && !zz_i;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_ni,
  input logic          adv_i,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          zz_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic          wake_busy
);
  assert_oe_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !oe_ni);

  assert_sleep_float_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |-> !dq_oe_o);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(dq_o));

  assert_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !zz_i && !wake_busy && !adv_i && ce_ni) |=> !dq_oe_o);

  assert_wake_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && wake_busy) |=> !dq_oe_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R13: assert (!dq_oe_o);
    end
  end
endmodule

bind zbt_sram zbt_sram_chk #(.DW(NB * BW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_ni   (cke_ni),
  .adv_i    (adv_i),
  .ce_ni    (ce_ni),
  .oe_ni    (oe_ni),
  .zz_i     (zz_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o),
  .wake_busy(wake_busy)
);

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0, adv = 1'b0, ce_n = 1'b1, rw = 1'b1, lbo = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic          oe_n = 1'b0, zz = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  always #10 clk = ~clk;

  zbt_sram #(.AW(AW), .NB(NB), .BW(BW), .WAKE_CYC(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .adv_i(adv), .ce_ni(ce_n),
    .rd_i(rw), .lbo_i(lbo), .bw_ni(bw_n), .oe_ni(oe_n), .zz_i(zz),
    .addr_i(addr), .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  int n_chk = 0, n_err = 0;
  string tag = "R13";
  bit done = 0;

  // behavioural reference
  logic [DW-1:0] mm [DEPTH];
  bit            m_act = 0, m_rd = 0, m_lin = 0;
  int            m_base = 0, m_cnt = 0, m_wake = 0;
  logic [NB-1:0] m_bw = '0;
  bit            p_vld = 0;
  int            p_addr = 0;
  logic [NB-1:0] p_bw = '0;
  logic [DW-1:0] p_data = '0;

  function automatic int cur_addr();
    int lo;
    if (m_lin) lo = (m_base + m_cnt) % 4;
    else       lo = (m_base % 4) ^ (m_cnt % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  function automatic logic [DW-1:0] exp_word();
    logic [DW-1:0] w;
    w = mm[cur_addr()];
    if (p_vld && p_addr == cur_addr())
      for (int b = 0; b < NB; b++) if (p_bw[b]) w[b*BW +: BW] = p_data[b*BW +: BW];
    return w;
  endfunction

  task automatic model_edge();
    bit ignore;
    ignore = zz || (m_wake > 0);
    if (!cke_n) begin
      if (p_vld)
        for (int b = 0; b < NB; b++) if (p_bw[b]) mm[p_addr][b*BW +: BW] = p_data[b*BW +: BW];
      p_vld  = m_act && !m_rd;
      p_addr = cur_addr();
      p_bw   = m_bw;
      p_data = din;
      m_bw   = ~bw_n;
      if (ignore) m_act = 0;
      else if (!adv) begin
        if (!ce_n) begin
          m_act = 1; m_rd = rw; m_base = int'(addr); m_cnt = 0; m_lin = lbo;
        end else m_act = 0;
      end else if (m_act) m_cnt = (m_cnt + 1) % 4;
    end
    if (zz) m_wake = 2;
    else if (m_wake > 0) m_wake--;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit eo;
    eo = m_act && m_rd && !oe_n && !zz;
    chk(tag, DW'(dq_oe_o), DW'(eo));
    if (eo) chk(tag, dq_o, exp_word());
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
    compare();
  endtask

  task automatic ld(input bit rd_op, input int a, input logic [NB-1:0] bwn, input logic [DW-1:0] d);
    cke_n = 0; adv = 0; ce_n = 0; rw = rd_op; addr = AW'(a); bw_n = bwn; din = d;
    tick();
  endtask

  task automatic cont(input logic [NB-1:0] bwn, input logic [DW-1:0] d);
    cke_n = 0; adv = 1; bw_n = bwn; din = d;
    tick();
  endtask

  task automatic desel(input logic [DW-1:0] d);
    cke_n = 0; adv = 0; ce_n = 1; din = d;
    tick();
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 16'h0123) ^ DW'(16'h5a5a);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #2;
    chk("R13", DW'(dq_oe_o), '0);
    rst_n = 1'b1;
    desel('0);
    chk("R13", DW'(dq_oe_o), '0);

    // R3: pipelined fill, data trails address by one edge
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) ld(0, i, '0, pat(i - 1));
    desel(pat(DEPTH - 1));

    tag = "R1";
    ld(1, 5, '1, '0);
    ld(1, 40, '1, '0);
    tag = "R2";
    oe_n = 1; ld(1, 6, '1, '0); oe_n = 0;
    ld(0, 8, '0, '0);

    // R4 / R5: byte-0 only write followed by read of same word
    tag = "R5";
    ld(0, 7, 2'b10, '0);
    ld(1, 7, '1, 16'hABCD);
    tag = "R4";
    ld(1, 7, '1, '0);
    ld(0, 9, '1, '0);
    ld(1, 9, '1, 16'hFFFF);
    ld(1, 9, '1, '0);
    ld(0, 10, 2'b01, '0);
    ld(1, 10, '1, 16'h1234);

    // R6: interleaved burst from low bits 01, plus wrap
    tag = "R6";
    ld(1, 13, '1, '0);
    for (int k = 0; k < 4; k++) cont('1, '0);

    // R7: linear order sampled at load only
    tag = "R7";
    lbo = 1; ld(1, 14, '1, '0); lbo = 0;
    for (int k = 0; k < 4; k++) cont('1, '0);

    // R8: write burst keeps type, then read it back
    tag = "R8";
    ld(0, 21, '0, '0);
    cont('0, 16'h1111);
    cont('0, 16'h2222);
    cont('0, 16'h3333);
    ld(1, 21, '1, 16'h4444);
    for (int k = 0; k < 3; k++) cont('1, '0);

    tag = "R9";
    desel('0);
    tag = "R8";
    cont('1, '0);
    cont('1, '0);

    // R10: stall holds read output and a pending write
    tag = "R10";
    ld(1, 12, '1, '0);
    held = dq_o;
    cke_n = 1; adv = 0; ce_n = 0; rw = 0; addr = 6'd33; din = 16'hDEAD;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10", dq_o, held);
      chk("R10", DW'(dq_oe_o), DW'(1));
    end
    cont('1, '0);
    ld(0, 30, '0, '0);
    cke_n = 1; tick(); tick();
    ld(1, 30, '1, 16'h7E57);
    ld(1, 30, '1, '0);

    // R11 / R12: sleep floats output, wake window ignores commands
    tag = "R11";
    ld(1, 3, '1, '0);
    zz = 1;
    #1;
    chk("R11", DW'(dq_oe_o), '0);
    for (int k = 0; k < 3; k++) ld(1, 3, '1, '0);
    zz = 0;
    tag = "R12";
    ld(1, 3, '1, '0);
    ld(1, 3, '1, '0);
    tag = "R11";
    ld(1, 3, '1, '0);
    chk("R11", DW'(dq_oe_o), DW'(1));
    ld(1, 7, '1, '0);
    desel('0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule